// File: doc/BRIEF.md
# Prescaled SPI baud generator

This block turns the module clock into a stream of single-cycle strobes that the SPI transfer engine uses to move the serial clock from one half-period to the next. The rate comes from two cascaded stages. A 5-bit prescaler comes first. A power-of-two divider follows it. The overall ratio N is the product of the two stages, so any value from 1 to 1024 that the two stages can form is available. One 16-bit clock-select word sets both stages, and that same setting serves transmit and receive.

Software writes the clock-select word at any time. The word is held in a staging register. It becomes the active setting only at an idle point, meaning a cycle where the engine reports frame idle and the serial clock enable is low. A frame that is already running therefore always finishes at the rate it started with. While the enable is low, both counters are cleared and held. When the enable rises, the first strobe comes one full interval of N cycles later.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, tick_o is low and the active setting is prescale 1 with divide-by-2, so N = 2.
- R2: tick_o is low in every cycle where run_i is low.
- R3: While run_i stays high, tick_o is high exactly in the N-th, 2N-th, 3N-th ... cycle of the run. The first cycle with run_i high counts as cycle 1.
- R4: Clock-select bits [12:8] hold the prescale value minus one, so a field value v gives a prescale of v+1 (1 to 32).
- R5: Clock-select bits [2:0] select the divider: code 0 divides by 2, 1 by 4, 2 by 8, 3 by 16, 4 by 32, and 7 by 1. N is the prescale times the divider.
- R6: Divider codes 5 and 6 divide by 1.
- R7: Clock-select bits [15:13] and [7:3] have no effect on the tick rate.
- R8: A written word becomes active at the first clock edge after the write where idle_i is high and run_i is low. A write while run_i is high, or while idle_i is low, leaves the current rate unchanged until such an edge.
- R9: Dropping run_i for one cycle clears both counters. The next run again gives its first tick in cycle N.
- R10: The extremes are reachable: word 0x1F04 gives N = 1024, and word 0x0007 gives a tick in every cycle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_wr_i | input | 1 | Write strobe for the clock-select word |
| sel_data_i | input | 16 | Clock-select word (halfword) |
| idle_i | input | 1 | Transfer engine is between frames |
| run_i | input | 1 | Serial clock enable; counters clear while low |
| tick_o | output | 1 | One-cycle half-period edge strobe |

## Verification
A write is captured at the first edge. It can become active at the next edge that meets the idle condition. For that reason the bench always leaves at least one idle edge between a write and the run that depends on it.

tick_o is built from the counter state and run_i with no further register. Its expected cycle is therefore simply the N-th cycle after the negative edge that raised run_i. The bench samples tick_o 1 ns after each negative edge and compares it against k mod N for every cycle k of a two-interval run. This catches early, late and missing strobes as well as extra ones.

Writes placed in the middle of a run, and writes made while idle_i is low, are checked the same way. In each case the tick positions must stay on the old N.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int unsigned SEL_W       = 16;
  localparam int unsigned PRE_W       = 5;
  localparam int unsigned PRE_LSB     = 8;
  localparam int unsigned CODE_W      = 3;
  localparam int unsigned CODE_LSB    = 0;
  localparam int unsigned DIV_LOG_MAX = 5;
  localparam int unsigned SHIFT_W     = $clog2(DIV_LOG_MAX + 1);

  typedef struct packed {
    logic [PRE_W-1:0]  pre_m1;
    logic [CODE_W-1:0] code;
  } baud_cfg_t;

  localparam baud_cfg_t CFG_RESET = '{pre_m1: '0, code: '0};

  // codes below DIV_LOG_MAX select 2^(code+1); all others bypass the divider
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [CODE_W-1:0] code);
    if (int'(code) < int'(DIV_LOG_MAX)) return SHIFT_W'(code) + SHIFT_W'(1);
    return '0;
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import spi_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] data_i,
  input  logic             idle_i,
  input  logic             run_i,
  output baud_cfg_t        cfg_o
);
  baud_cfg_t stage_q, act_q;
  logic      apply;

  assign apply = idle_i & ~run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= CFG_RESET;
      act_q   <= CFG_RESET;
    end else begin
      if (wr_i) begin
        stage_q.pre_m1 <= data_i[PRE_LSB +: PRE_W];
        stage_q.code   <= data_i[CODE_LSB +: CODE_W];
      end
      if (apply) act_q <= stage_q;
    end
  end

  assign cfg_o = act_q;

  assert_act_stable_in_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(act_q));
  assert_act_stable_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(act_q));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_m1_i,
  output logic             wrap_o
);
  logic [PRE_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == pre_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PRE_W'(1);
  end

  assert_pre_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
  assert_pre_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= pre_m1_i);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned DIV_LOG_MAX = 5,
  parameter int unsigned SHIFT_W     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               step_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               last_o
);
  localparam int unsigned DIV_W = DIV_LOG_MAX;

  logic [DIV_W:0]   one_sh;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] cnt_q;

  assign one_sh = (DIV_W+1)'(1) << shift_i;
  assign mask   = DIV_W'(one_sh - (DIV_W+1)'(1));
  assign last_o = (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + DIV_W'(1);
  end

  always_comb begin
    assert_shift_range_R5: assert (int'(shift_i) <= int'(DIV_LOG_MAX));
  end

  assert_div_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= mask);
  assert_div_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_data_i,
  input  logic             idle_i,
  input  logic             run_i,
  output logic             tick_o
);
  baud_cfg_t          cfg;
  logic               pre_wrap;
  logic               div_last;
  logic [SHIFT_W-1:0] shift;

  assign shift = div_shift(cfg.code);

  baud_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (sel_wr_i),
    .data_i (sel_data_i),
    .idle_i (idle_i),
    .run_i  (run_i),
    .cfg_o  (cfg)
  );

  baud_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .pre_m1_i (cfg.pre_m1),
    .wrap_o   (pre_wrap)
  );

  baud_divider #(.DIV_LOG_MAX(DIV_LOG_MAX), .SHIFT_W(SHIFT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .step_i  (pre_wrap),
    .shift_i (shift),
    .last_o  (div_last)
  );

  assign tick_o = run_i & pre_wrap & div_last;

  // back-to-back ticks only at unity ratio
  assert_b2b_only_unity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(tick_o)) |-> (cfg.pre_m1 == '0 && shift == '0));
  assert_first_cycle_tick_unity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !$past(run_i)) |-> (cfg.pre_m1 == '0 && shift == '0));
  assert_no_tick_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
endmodule

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_wr_i = 1'b0;
  logic [15:0] sel_data_i = '0;
  logic        idle_i = 1'b1;
  logic        run_i = 1'b0;
  logic        tick_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  spi_baud_gen u_spi_baud_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_wr_i   (sel_wr_i),
    .sel_data_i (sel_data_i),
    .idle_i     (idle_i),
    .run_i      (run_i),
    .tick_o     (tick_o)
  );

  // {clock-select word, expected N}
  localparam int NVEC = 14;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 16'd2},    // R5 code0
    {16'h0001, 16'd4},    // R5
    {16'h0002, 16'd8},    // R5
    {16'h0003, 16'd16},   // R5
    {16'h0004, 16'd32},   // R5
    {16'h0007, 16'd1},    // R5 R10
    {16'h0005, 16'd1},    // R6
    {16'h0006, 16'd1},    // R6
    {16'h1F00, 16'd64},   // R4
    {16'h1F04, 16'd1024}, // R10
    {16'h0407, 16'd5},    // R4
    {16'h0A03, 16'd176},  // R4 R5
    {16'hE0F8, 16'd2},    // R7
    {16'h1F07, 16'd32}    // R4
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic [15:0] w);
    @(negedge clk_i);
    sel_wr_i = 1'b1;
    sel_data_i = w;
    @(negedge clk_i);
    sel_wr_i = 1'b0;
  endtask

  // run for 2N cycles, ticks expected exactly at k % N == 0; optional write at cycle wr_at
  task automatic run_check(input int exp_n, input int wr_at, input logic [15:0] wr_val,
                           input string req);
    int bad = 0;
    int bad_k = 0;
    @(negedge clk_i);
    run_i = 1'b1;
    for (int k = 1; k <= 2 * exp_n; k++) begin
      if (k == wr_at) begin
        sel_wr_i = 1'b1;
        sel_data_i = wr_val;
      end else begin
        sel_wr_i = 1'b0;
      end
      #1;
      if (tick_o !== ((k % exp_n) == 0)) begin
        if (bad == 0) bad_k = k;
        bad++;
      end
      @(negedge clk_i);
    end
    sel_wr_i = 1'b0;
    run_i = 1'b0;
    check(bad == 0, req, bad_k, 0);
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R3 watchdog actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    #1;
    check(tick_o == 1'b0, "R1 tick in reset", tick_o, 0);
    #22;
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check(tick_o == 1'b0, "R1 tick after reset", tick_o, 0);
    run_check(2, 0, 16'h0, "R1 default ratio 2");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      write_sel(VEC[i][31:16]);
      @(negedge clk_i);
      run_check(int'(VEC[i][15:0]), 0, 16'h0, $sformatf("R3 R5 vector %0d", i));
    end

    // R2: run low, no tick
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      #1;
      if (tick_o) cnt++;
    end
    check(cnt == 0, "R2 ticks while run low", cnt, 0);

    // R8: write while busy is held back
    idle_i = 1'b0;
    write_sel(16'h0007);
    @(negedge clk_i);
    run_check(32, 0, 16'h0, "R8 busy write held");
    idle_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    run_check(1, 0, 16'h0, "R8 applied at idle");

    // R8: write mid-run does not disturb the run
    write_sel(16'h0001);
    @(negedge clk_i);
    run_check(4, 3, 16'h0007, "R8 mid-run write ignored");
    run_check(1, 0, 16'h0, "R8 mid-run write applied after");

    // R9: partial run, drop, restart
    write_sel(16'h0002);
    @(negedge clk_i);
    cnt = 0;
    run_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1;
      if (tick_o) cnt++;
      @(negedge clk_i);
    end
    run_i = 1'b0;
    check(cnt == 0, "R9 partial run no tick", cnt, 0);
    run_check(8, 0, 16'h0, "R9 restart full interval");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule